// File: doc/BRIEF.md
# Fault Capture Register with Single-Shot Machine-Error Request

This block gathers hardware fault indications into a sticky fault register and turns them into a machine-error interrupt request. Eight active-low external fault lines and one internal bus-timeout indication are sampled on the rising edge of `clk_i`, which stands for the processor's synchronizing clock edge. Any newly captured fault emits a one-cycle `lvl1_set_o` strobe that the pending-interrupt logic uses to set its level-1 bit. An anti-repeat flag allows only one such strobe per fault episode. The flag re-arms only when the fault register has been emptied, so persistent fault bits cannot retrigger the interrupt after the pending bit is serviced.

Three fault bits (positions 0, 5 and 8) also stop the running instruction. When one of them is newly set, `abort_no` pulses low. While a DMA cycle is in progress or hold is asserted, those three bits are not captured. Software reaches the register through a 3-bit command code. It can read the register without changing it, read and clear it in one step, or load it from the data bus.

Top module: `fault_latch`

## Requirements
- R1: After reset the fault register is zero, `lvl1_set_o` is 0, `abort_no` is 1, `rd_valid_o` is 0 and `data_o` is 0.
- R2: A low on `fault_ni[i]` at a clock edge sets fault bit i, and a high `bus_tmo_i` sets bit 8. Set bits stay set after the input returns to its idle level, until a clear or a load.
- R3: Capturing a fault that is not already set, while the request path is armed, drives `lvl1_set_o` high for exactly the one cycle after that edge. Any strobe implies a non-zero fault register.
- R4: Once a strobe has been sent, later new faults produce no strobe while the fault register stays non-zero.
- R5: Command 3'b110 (peek) gives `rd_valid_o`=1 in the next cycle, with `data_o` holding the register value from before the edge. The register is unchanged.
- R6: Command 3'b111 (take) returns the register like a peek, then clears it and re-arms the request path.
- R7: Command 3'b001 (load) writes `data_i` into the register with no strobe and no abort. Loading zero re-arms the request path.
- R8: When bit 0, 5 or 8 changes from 0 to 1 through capture, `abort_no` is low for the following cycle. A bit already set does not pulse it again.
- R9: While `dma_cyc_i` is 1 or `hold_ni` is 0, bits 0, 5 and 8 are not captured. The other bits are captured as usual.
- R10: When a take and a new fault fall in the same cycle, the new fault is kept in the register and raises a strobe.
- R11: The other command codes (000, 010, 011, 100, 101) leave the register and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Synchronizing clock; capture on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_ni | input | 8 | External fault lines, active low |
| bus_tmo_i | input | 1 | Internal bus-timeout fault (bit 8), active high |
| dma_cyc_i | input | 1 | DMA cycle in progress |
| hold_ni | input | 1 | Hold state, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code |
| data_i | input | 9 | Load value for the fault register |
| data_o | output | 9 | Read result, zero when not valid |
| rd_valid_o | output | 1 | Read result valid |
| lvl1_set_o | output | 1 | One-cycle machine-error set strobe |
| abort_no | output | 1 | Instruction abort, active-low pulse |

## Verification
A take that clears the register can land in the same cycle as a new fault. The bench provokes this by driving command 3'b111 while a fault line is low. It expects the old contents on `data_o`, a strobe, because the take re-arms the request path, and only the new bit on the next peek. A load landing in the same cycle as a suppressed abort-class fault is judged the same way, through later peeks.

// File: rtl/fault_latch_pkg.sv
package fault_latch_pkg;
  typedef enum logic [2:0] {
    CMD_LOAD = 3'b001,
    CMD_PEEK = 3'b110,
    CMD_TAKE = 3'b111
  } fl_cmd_e;
endpackage

// File: rtl/fl_qualify.sv
module fl_qualify #(
  parameter int unsigned      N_EXT      = 8,
  parameter logic [N_EXT:0]   ABORT_MASK = 9'h121
) (
  input  logic [N_EXT-1:0] fault_ni,
  input  logic             bus_tmo_i,
  input  logic             dma_cyc_i,
  input  logic             hold_ni,
  output logic [N_EXT:0]   cap_o
);
  localparam int unsigned NF = N_EXT + 1;

  logic          blk;
  logic [N_EXT:0] raw;

  assign blk = dma_cyc_i | ~hold_ni;

  for (genvar i = 0; i < NF; i++) begin : g_bit
    if (i < N_EXT) begin : g_ext
      assign raw[i] = ~fault_ni[i];
    end else begin : g_int
      assign raw[i] = bus_tmo_i;
    end
    if (ABORT_MASK[i]) begin : g_gated
      assign cap_o[i] = raw[i] & ~blk;
    end else begin : g_open
      assign cap_o[i] = raw[i];
    end
  end
endmodule

// File: rtl/fl_store.sv
module fl_store #(
  parameter int unsigned N_EXT = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_EXT:0] cap_i,
  input  logic           load_i,
  input  logic           take_i,
  input  logic [N_EXT:0] data_i,
  output logic [N_EXT:0] ft_o,
  output logic [N_EXT:0] rising_o,
  output logic           base_zero_o
);
  logic [N_EXT:0] ft_q, base;

  // command acts first, captures are ORed on top so none is lost
  always_comb begin
    if (load_i)      base = data_i;
    else if (take_i) base = '0;
    else             base = ft_q;
  end

  assign rising_o    = cap_i & ~base;
  assign base_zero_o = (base == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ft_q <= '0;
    else         ft_q <= base | cap_i;
  end

  assign ft_o = ft_q;
endmodule

// File: rtl/fl_arm.sv
module fl_arm #(
  parameter int unsigned    N_EXT      = 8,
  parameter logic [N_EXT:0] ABORT_MASK = 9'h121
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_EXT:0] rising_i,
  input  logic           base_zero_i,
  output logic           lvl1_o,
  output logic           abort_no
);
  logic armed_q, armed_eff, fire;
  logic lvl1_q, abort_q;

  assign armed_eff = armed_q | base_zero_i;
  assign fire      = armed_eff & (|rising_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      lvl1_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      armed_q <= fire ? 1'b0 : armed_eff;
      lvl1_q  <= fire;
      abort_q <= |(rising_i & ABORT_MASK);
    end
  end

  assign lvl1_o   = lvl1_q;
  assign abort_no = ~abort_q;
endmodule

// File: rtl/fault_latch.sv
module fault_latch
  import fault_latch_pkg::*;
#(
  parameter int unsigned    N_EXT      = 8,
  parameter logic [N_EXT:0] ABORT_MASK = 9'h121
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] fault_ni,
  input  logic             bus_tmo_i,
  input  logic             dma_cyc_i,
  input  logic             hold_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_i,
  input  logic [N_EXT:0]   data_i,
  output logic [N_EXT:0]   data_o,
  output logic             rd_valid_o,
  output logic             lvl1_set_o,
  output logic             abort_no
);
  logic [N_EXT:0] cap, fault_q, rising;
  logic           base_zero;
  logic           load_c, take_c, peek_c;
  logic           rd_valid_q;
  logic [N_EXT:0] rd_data_q;

  assign load_c = cmd_valid_i && (cmd_i == CMD_LOAD);
  assign take_c = cmd_valid_i && (cmd_i == CMD_TAKE);
  assign peek_c = cmd_valid_i && (cmd_i == CMD_PEEK);

  fl_qualify #(.N_EXT(N_EXT), .ABORT_MASK(ABORT_MASK)) u_qual (
    .fault_ni (fault_ni),
    .bus_tmo_i(bus_tmo_i),
    .dma_cyc_i(dma_cyc_i),
    .hold_ni  (hold_ni),
    .cap_o    (cap)
  );

  fl_store #(.N_EXT(N_EXT)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .load_i     (load_c),
    .take_i     (take_c),
    .data_i     (data_i),
    .ft_o       (fault_q),
    .rising_o   (rising),
    .base_zero_o(base_zero)
  );

  fl_arm #(.N_EXT(N_EXT), .ABORT_MASK(ABORT_MASK)) u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rising_i   (rising),
    .base_zero_i(base_zero),
    .lvl1_o     (lvl1_set_o),
    .abort_no   (abort_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= peek_c | take_c;
      rd_data_q  <= (peek_c | take_c) ? fault_q : '0;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign data_o     = rd_data_q;
endmodule

// File: rtl/fault_latch_chk.sv
module fault_latch_chk
  import fault_latch_pkg::*;
#(
  parameter int unsigned    N_EXT      = 8,
  parameter logic [N_EXT:0] ABORT_MASK = 9'h121
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_EXT-1:0] fault_ni,
  input logic             bus_tmo_i,
  input logic             dma_cyc_i,
  input logic             hold_ni,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_i,
  input logic [N_EXT:0]   data_o,
  input logic             rd_valid_o,
  input logic             lvl1_set_o,
  input logic             abort_no,
  input logic [N_EXT:0]   fault_q
);
  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cmd_valid_i) |-> ((fault_q & $past(fault_q)) == $past(fault_q)));

  assert_strobe_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl1_set_o |-> (fault_q != '0));

  assert_single_shot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lvl1_set_o) && !$past(cmd_valid_i)) |-> !lvl1_set_o);

  assert_peek_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_valid_i && cmd_i == CMD_PEEK) |->
      (rd_valid_o && data_o == $past(fault_q) && fault_q == $past(fault_q)));

  assert_take_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_valid_i && cmd_i == CMD_TAKE && (&fault_ni) && !bus_tmo_i) |->
      (fault_q == '0 && rd_valid_o));

  assert_abort_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_no |-> ((fault_q & ABORT_MASK) != '0));

  assert_suppress_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past((dma_cyc_i || !hold_ni) && !cmd_valid_i) |->
      ((fault_q & ABORT_MASK) == ($past(fault_q) & ABORT_MASK)));
endmodule

bind fault_latch fault_latch_chk #(.N_EXT(N_EXT), .ABORT_MASK(ABORT_MASK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fault_ni   (fault_ni),
  .bus_tmo_i  (bus_tmo_i),
  .dma_cyc_i  (dma_cyc_i),
  .hold_ni    (hold_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_i      (cmd_i),
  .data_o     (data_o),
  .rd_valid_o (rd_valid_o),
  .lvl1_set_o (lvl1_set_o),
  .abort_no   (abort_no),
  .fault_q    (fault_q)
);

// File: tb/fault_latch_bench.sv
`timescale 1ns/1ps
module fault_latch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fault_n = 8'hFF;
  logic       tmo = 1'b0, dma = 1'b0, hold_n = 1'b1;
  logic       cv = 1'b0;
  logic [2:0] cmd = 3'b000;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       rv, lvl1, ab_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic       lvl1;
    logic       abn;
    logic       rv;
    logic [8:0] data;
    string      req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  fault_latch u_fault_latch (
    .clk_i(clk), .rst_ni(rst_n), .fault_ni(fault_n), .bus_tmo_i(tmo),
    .dma_cyc_i(dma), .hold_ni(hold_n), .cmd_valid_i(cv), .cmd_i(cmd),
    .data_i(din), .data_o(dout), .rd_valid_o(rv), .lvl1_set_o(lvl1),
    .abort_no(ab_n)
  );

  task automatic chk(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per cycle, samples after the edge
  always @(posedge clk) begin
    exp_t e;
    #5;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      chk(e.req, "lvl1_set_o", {8'h0, lvl1}, {8'h0, e.lvl1});
      chk(e.req, "abort_no", {8'h0, ab_n}, {8'h0, e.abn});
      chk(e.req, "rd_valid_o", {8'h0, rv}, {8'h0, e.rv});
      chk(e.req, "data_o", dout, e.data);
    end
  end

  task automatic step(input logic [7:0] fn, input logic t, input logic d, input logic hn,
                      input logic c_v, input logic [2:0] c, input logic [8:0] di,
                      input logic el, input logic eab, input logic erv, input logic [8:0] ed,
                      input string req);
    exp_t e;
    @(negedge clk);
    fault_n = fn; tmo = t; dma = d; hold_n = hn; cv = c_v; cmd = c; din = di;
    e.lvl1 = el; e.abn = eab; e.rv = erv; e.data = ed; e.req = req;
    sb.push_back(e);
  endtask

  task automatic peek(input logic [8:0] ed, input string req);
    step(8'hFF, 0, 0, 1, 1, 3'b110, '0, 0, 1, 1, ed, req);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R1", "lvl1 in reset", {8'h0, lvl1}, 9'h000);
    chk("R1", "abort in reset", {8'h0, ab_n}, 9'h001);
    chk("R1", "rv in reset", {8'h0, rv}, 9'h000);
    chk("R1", "data in reset", dout, 9'h000);
    @(negedge clk);
    rst_n = 1'b1;

    peek(9'h000, "R1");
    step(~8'h02, 0, 0, 1, 0, 3'b000, '0, 1, 1, 0, '0, "R3");   // bit1 first capture
    peek(9'h002, "R2");                                        // sticky after release
    step(~8'h08, 0, 0, 1, 0, 3'b000, '0, 0, 1, 0, '0, "R4");   // no second strobe
    peek(9'h00A, "R4");
    peek(9'h00A, "R5");                                        // non-destructive
    step(8'hFF, 0, 0, 1, 1, 3'b111, '0, 0, 1, 1, 9'h00A, "R6");
    peek(9'h000, "R6");
    step(~8'h01, 0, 0, 1, 0, 3'b000, '0, 1, 0, 0, '0, "R8");   // re-armed, bit0 aborts
    step(8'hFF, 0, 0, 1, 0, 3'b000, '0, 0, 1, 0, '0, "R8");    // pulse is one cycle
    step(~8'h01, 1, 0, 1, 0, 3'b000, '0, 0, 0, 0, '0, "R8");   // bit8 aborts, bit0 held
    peek(9'h101, "R8");
    step(8'hFF, 0, 0, 1, 1, 3'b111, '0, 0, 1, 1, 9'h101, "R6");
    step(~8'h21, 1, 1, 1, 0, 3'b000, '0, 0, 1, 0, '0, "R9");   // DMA blocks 0,5,8
    peek(9'h000, "R9");
    step(~8'h24, 0, 0, 0, 0, 3'b000, '0, 1, 1, 0, '0, "R9");   // hold: bit2 only
    peek(9'h004, "R9");
    step(8'hFF, 0, 0, 1, 1, 3'b001, 9'h1E0, 0, 1, 0, '0, "R7");
    peek(9'h1E0, "R7");
    step(8'hFF, 0, 0, 1, 1, 3'b001, 9'h000, 0, 1, 0, '0, "R7");
    step(~8'h80, 0, 0, 1, 0, 3'b000, '0, 1, 1, 0, '0, "R7");   // zero load re-armed
    peek(9'h080, "R7");
    step(~8'h10, 0, 0, 1, 1, 3'b111, '0, 1, 1, 1, 9'h080, "R10");
    peek(9'h010, "R10");
    step(8'hFF, 0, 0, 1, 1, 3'b000, 9'h1FF, 0, 1, 0, '0, "R11");
    step(8'hFF, 0, 0, 1, 1, 3'b010, 9'h1FF, 0, 1, 0, '0, "R11");
    step(8'hFF, 0, 0, 1, 1, 3'b011, 9'h1FF, 0, 1, 0, '0, "R11");
    step(8'hFF, 0, 0, 1, 1, 3'b100, 9'h1FF, 0, 1, 0, '0, "R11");
    step(8'hFF, 0, 0, 1, 1, 3'b101, 9'h1FF, 0, 1, 0, '0, "R11");
    peek(9'h010, "R11");
    step(~8'h10, 0, 0, 1, 0, 3'b000, '0, 0, 1, 0, '0, "R4");   // held fault, no strobe
    step(8'hFF, 0, 0, 1, 0, 3'b000, '0, 0, 1, 0, '0, "R4");

    repeat (3) @(posedge clk);
    #6;
    chk("R1", "scoreboard drained", 9'(sb.size()), 9'h000);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule